// File: doc/BRIEF.md
# Set-Associative Pseudo-LRU Victim Selector

This block holds the replacement state of every set in a set-associative cache and names the way to evict when a miss needs a line. The cache presents a set index, and whenever a hit or a line fill touches a way of that set, it raises an access strobe together with the way number. The block updates only the state of that set. The victim output always shows the choice for the set that is currently indexed, so the miss path can read it in the same cycle.

The block can be built for 1, 2 or 4 ways. With one way there is nothing to choose, so no state is kept and the victim is always way 0. With two ways each set keeps a single bit that points away from the most recently used way. With four ways each set keeps a three-bit binary decision tree instead of a full recency ordering. A full ordering would need 24 states per set. The tree gives approximate recency from very little storage.

Top module: `plru_victim_sel`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the state of every set, so after reset the victim of every set is way 0.
- R2: With WAYS=1 the victim output is 0 at all times, whatever accesses occur.
- R3: With WAYS=2 the victim is the way named by the set's single bit. An access to way w sets that bit to the other way (1-w).
- R4: With WAYS=4 a set's state is three bits: a root bit, a bit for the lower pair (ways 0,1) and a bit for the upper pair (ways 2,3). The victim's upper bit equals the root bit. Its lower bit equals the lower-pair bit when the root is 0, and the upper-pair bit when the root is 1.
- R5: With WAYS=4 an access to way w sets the root bit to point at the pair not containing w. It also sets the bit of w's own pair to point at w's sibling, so the next victim of that set lies in the other pair.
- R6: With WAYS=4 an access leaves the bit of the pair not containing w unchanged.
- R7: A cycle without the access strobe is a lookup only and changes no state. The acc_way value is ignored in such a cycle.
- R8: An access changes only the state of the set on set_idx. All other sets keep their state.
- R9: The victim is combinational from the stored state of the indexed set. An access becomes visible only after the clock edge that samples the strobe, so during the access cycle the victim still shows the old choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | $clog2(SETS) | Set being looked up or accessed |
| acc_en | input | 1 | Hit or fill strobe: updates the indexed set |
| acc_way | input | $clog2(WAYS) (min 1) | Way touched by the access |
| victim | output | $clog2(WAYS) (min 1) | Way to evict for the indexed set |

## Verification
On every cycle the assertions check four things:
- reset clears the indexed set;
- a direct-mapped build always names way 0;
- an access is followed by a victim that differs from the accessed way (and, with four ways, lies in the other pair) when the index holds;
- the victim stays steady across lookup-only cycles.

Other behaviour needs the bench's sequences and expected values computed from the tree rules:
- exact tree contents over a chain of accesses;
- the untouched pair keeping its bit;
- independence of sets;
- the victim keeping its old value during the access cycle.

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             acc_en,
  input  logic [WAY_W-1:0] acc_way,
  output logic [WAY_W-1:0] victim
);

  generate
    if (WAYS == 1) begin : g_direct
      logic unused_in;
      assign unused_in = ^{clk, rst, set_idx, acc_en, acc_way};
      assign victim = '0;
    end else if (WAYS == 2) begin : g_two
      logic [SETS-1:0] ptr;
      always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (acc_en) ptr[set_idx] <= ~acc_way[0];
      end
      assign victim = ptr[set_idx];
    end else begin : g_four
      // bit 0: root (1 = upper pair), bit 1: lower pair, bit 2: upper pair
      logic [2:0] tree [SETS];
      logic [2:0] cur;
      assign cur    = tree[set_idx];
      assign victim = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < SETS; i++) tree[i] <= '0;
        end else if (acc_en) begin
          tree[set_idx][0] <= ~acc_way[1];
          if (acc_way[1]) tree[set_idx][2] <= ~acc_way[0];
          else            tree[set_idx][1] <= ~acc_way[0];
        end
      end
    end
  endgenerate

endmodule

module plru_victim_sel_chk #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [SET_W-1:0] set_idx,
  input logic             acc_en,
  input logic [WAY_W-1:0] acc_way,
  input logic [WAY_W-1:0] victim
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> victim == '0); // R1

  AST_LOOKUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (set_idx != $past(set_idx)) || $stable(victim)); // R7

  generate
    if (WAYS == 1) begin : g_a1
      AST_DIRECT_ZERO: assert property (@(posedge clk) victim == '0); // R2
    end else begin : g_an
      AST_AWAY_FROM_USED: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (set_idx != $past(set_idx)) || (victim != $past(acc_way))); // R3
      if (WAYS == 4) begin : g_a4
        AST_OTHER_PAIR: assert property (@(posedge clk) disable iff (rst)
          acc_en |=> (set_idx != $past(set_idx)) ||
                     (victim[WAY_W-1] != $past(acc_way[WAY_W-1]))); // R5
      end
    end
  endgenerate

endmodule

bind plru_victim_sel plru_victim_sel_chk #(.SETS(SETS), .WAYS(WAYS)) chk (.*);

// File: tb/plru_victim_sel_test.sv
module plru_victim_sel_test;
  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [3:0] set_idx = '0;
  logic       acc_en = 0;
  logic [1:0] acc_way = '0;
  logic [1:0] victim;

  logic [1:0] s2_idx = '0;
  logic       s2_en = 0, s2_way = 0, s2_vic;
  logic [1:0] s1_idx = '0;
  logic       s1_en = 0, s1_way = 0, s1_vic;

  plru_victim_sel #(.SETS(16), .WAYS(4)) uut
    (.clk, .rst, .set_idx, .acc_en, .acc_way, .victim);
  plru_victim_sel #(.SETS(4), .WAYS(2)) uut_w2
    (.clk, .rst, .set_idx(s2_idx), .acc_en(s2_en), .acc_way(s2_way), .victim(s2_vic));
  plru_victim_sel #(.SETS(4), .WAYS(1)) uut_w1
    (.clk, .rst, .set_idx(s1_idx), .acc_en(s1_en), .acc_way(s1_way), .victim(s1_vic));

  int checks = 0, failures = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {set[3:0], en, way[1:0], expected victim after the edge[1:0]}
  localparam int NV = 9;
  localparam bit [8:0] VEC [NV] = '{
    {4'd3, 1'b1, 2'd0, 2'd2},
    {4'd3, 1'b1, 2'd2, 2'd1},
    {4'd3, 1'b1, 2'd1, 2'd3},
    {4'd3, 1'b1, 2'd3, 2'd0},
    {4'd3, 1'b1, 2'd1, 2'd2},
    {4'd3, 1'b1, 2'd2, 2'd0},
    {4'd3, 1'b1, 2'd0, 2'd3},
    {4'd3, 1'b0, 2'd0, 2'd3},
    {4'd5, 1'b0, 2'd2, 2'd0}
  };

  task automatic step4(input logic [3:0] s, input logic e, input logic [1:0] w);
    @(negedge clk);
    set_idx = s; acc_en = e; acc_way = w;
    @(negedge clk);
    acc_en = 0;
  endtask

  initial begin
    #4_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: every set starts with victim way 0
    for (int i = 0; i < 16; i++) begin
      set_idx = 4'(i);
      #1 chk("R1 reset victim", victim, 0);
    end
    chk("R1 reset victim 2-way", s2_vic, 0);

    // R4 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      step4(VEC[i][8:5], VEC[i][4], VEC[i][3:2]);
      chk($sformatf("R5 R6 R7 vector %0d", i), victim, VEC[i][1:0]);
    end

    // R8: access in set 5 leaves set 3 alone
    step4(4'd5, 1'b1, 2'd0);
    chk("R8 set 5 updated", victim, 2);
    set_idx = 4'd3; #1;
    chk("R8 set 3 kept", victim, 3);

    // R9: during the access cycle the old victim is still shown
    @(negedge clk);
    set_idx = 4'd3; acc_en = 1; acc_way = 2'd2;
    #1 chk("R9 old victim during access", victim, 3);
    @(negedge clk);
    acc_en = 0;
    chk("R9 new victim after edge", victim, 1);

    // R3: 2-way pointer
    @(negedge clk); s2_idx = 2'd1; s2_en = 1; s2_way = 0;
    @(negedge clk); s2_en = 0;
    chk("R3 2-way after way 0", s2_vic, 1);
    @(negedge clk); s2_en = 1; s2_way = 1;
    @(negedge clk); s2_en = 0;
    chk("R3 2-way after way 1", s2_vic, 0);
    @(negedge clk); s2_en = 1; s2_way = 1;
    @(negedge clk); s2_en = 0;
    chk("R3 2-way repeat way 1", s2_vic, 0);
    s2_idx = 2'd2; #1 chk("R8 2-way other set", s2_vic, 0);

    // R2: direct-mapped
    @(negedge clk); s1_idx = 2'd2; s1_en = 1; s1_way = 1;
    @(negedge clk); s1_en = 0;
    chk("R2 direct victim", s1_vic, 0);

    // R1: reset after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    set_idx = 4'd3; #1 chk("R1 reset after use set 3", victim, 0);
    set_idx = 4'd5; #1 chk("R1 reset after use set 5", victim, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule